// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog countdown timer behind a simple 32-bit register interface with a write strobe, a word address and a combinational read-data path. Software can start or stop the countdown only by writing a pair of key words, back to back, to the count register. A start pair begins the countdown. A stop pair halts the countdown and restores the programmed default count. Any other value written to the count register while the timer is idle becomes the new default count. Reading the count register always returns the live count.

When a running count reaches zero, the block raises its reset output for a programmable number of reference-clock ticks. The reference clock is assumed to run at 50 MHz. The count then returns to the default and the timer stays idle. Writing a one to bit 0 of the soft-reset register raises the same pulse on demand.

The controller is a three-state machine:
- WS_STOP: idle, count held at the default.
- WS_RUN: counting down once per clock.
- WS_FIRE: reset pulse active, timer idle.

Its transitions are:
- START (WS_STOP to WS_RUN): a start pair completes.
- HALT (WS_RUN to WS_STOP): a stop pair completes.
- EXPIRE (WS_RUN to WS_FIRE): the count is zero at a clock edge.
- SOFT (any state to WS_FIRE): a soft-reset request is written. In WS_FIRE this restarts the pulse.
- RELEASE (WS_FIRE to WS_STOP): the pulse length runs out.

Top module: `wdt_keyed`

## Requirements
- R1: Writing 0x0000FF00 and then, on the very next write, 0x000000FF to the count register (offset 0) starts the timer from WS_STOP. The count is unchanged at that edge and then decreases by one on every following clock.
- R2: Writing 0x0000EE00 and then, on the very next write, 0x000000EE to offset 0 while running stops the timer. At that same edge the count is reloaded with the default count, and it then stays there.
- R3: A read of offset 0 returns the live count, zero-extended. A read of offset 1 returns the pulse-length register. A read of offset 2 returns zero.
- R4: A write of a non-key value to offset 0 while not running sets both the default count and the live count to that value. While running, such a write changes neither, and the countdown continues.
- R5: Any write other than the matching second word discards a partially matched pair. This includes a write to another offset or a first word of the other pair. A first key word always begins a new match. The four key words are never loaded as a count.
- R6: If the timer is running with a count of zero at a clock edge and no write completes a stop pair, the next cycle has the reset output high, the timer idle and the count equal to the default.
- R7: The reset output stays high for exactly N cycles, where N is the value of offset 1 at the time the pulse starts. A value of 0 acts as 1.
- R8: Writing a 1 in bit 0 of offset 2 raises the reset output on the next cycle for N cycles, stops the timer and reloads the count. Writing a 0 there has no effect.
- R9: A synchronous reset (rst high) leaves the reset output low, the timer idle, the default and live counts all ones, and offset 1 equal to parameter PULSE_RST.
- R10: A start pair completed while the reset pulse is active is ignored. After the pulse ends, the timer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Word offset: 0 count, 1 pulse length, 2 soft reset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| wdt_rst_o | output | 1 | Reset pulse output |

## Verification
The bench builds the block with CNT_W = 16, PULSE_W = 8 and PULSE_RST = 4. With these values, a default count of 10 reaches expiry within a few tens of cycles, so expiry, the full pulse and the return to idle can all be observed many times in one run. The narrow widths also make the reset value of all ones (0xFFFF) directly checkable, and let pulse lengths of 0, 3, 4 and 6 ticks be compared exactly against a per-cycle behavioural model.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    typedef enum logic [1:0] {
        WS_STOP = 2'd0,
        WS_RUN  = 2'd1,
        WS_FIRE = 2'd2
    } wdt_state_e;

    typedef enum logic [1:0] {
        KP_NONE  = 2'd0,
        KP_START = 2'd1,
        KP_STOP  = 2'd2
    } key_pend_e;

    localparam logic [31:0] KEY_GO_A   = 32'h0000_FF00;
    localparam logic [31:0] KEY_GO_B   = 32'h0000_00FF;
    localparam logic [31:0] KEY_HALT_A = 32'h0000_EE00;
    localparam logic [31:0] KEY_HALT_B = 32'h0000_00EE;

    localparam int OFS_COUNT = 0;
    localparam int OFS_TICKS = 1;
    localparam int OFS_SOFT  = 2;

endpackage

// File: rtl/wdt_key_detect.sv
module wdt_key_detect
    import wdt_keyed_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        sel_count,
    input  logic [31:0] wdata,
    output logic        start_evt,
    output logic        stop_evt,
    output logic        is_key
);

    key_pend_e pend_q;
    key_pend_e pend_d;

    always_comb begin
        is_key    = (wdata == KEY_GO_A) || (wdata == KEY_GO_B) ||
                    (wdata == KEY_HALT_A) || (wdata == KEY_HALT_B);
        start_evt = wr_en && sel_count && (wdata == KEY_GO_B) && (pend_q == KP_START);
        stop_evt  = wr_en && sel_count && (wdata == KEY_HALT_B) && (pend_q == KP_STOP);
        pend_d    = pend_q;
        if (wr_en) begin
            if (sel_count && wdata == KEY_GO_A) begin
                pend_d = KP_START;
            end else if (sel_count && wdata == KEY_HALT_A) begin
                pend_d = KP_STOP;
            end else begin
                pend_d = KP_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= KP_NONE;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/wdt_pulse_len.sv
module wdt_pulse_len #(
    parameter int PULSE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               active,
    input  logic [PULSE_W-1:0] ticks,
    output logic               last
);

    logic [PULSE_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= ticks;
        end else if (active && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q <= PULSE_W'(1));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_W   = 32,
    parameter int ADDR_W    = 2,
    parameter int PULSE_RST = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              wdt_rst_o
);

    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_TICKS = ADDR_W'(OFS_TICKS);
    localparam logic [ADDR_W-1:0] A_SOFT  = ADDR_W'(OFS_SOFT);

    wdt_state_e         state_q;
    wdt_state_e         state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   dflt_q;
    logic [PULSE_W-1:0] ticks_q;

    logic wr_cnt;
    logic soft_req;
    logic start_evt;
    logic stop_evt;
    logic is_key;
    logic load_val;
    logic pulse_load;
    logic pulse_last;

    assign wr_cnt   = wr_en && (addr == A_COUNT);
    assign soft_req = wr_en && (addr == A_SOFT) && wdata[0];
    assign load_val = wr_cnt && !is_key && (state_q != WS_RUN);

    wdt_key_detect u_keys (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .sel_count (addr == A_COUNT),
        .wdata     (wdata),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .is_key    (is_key)
    );

    assign pulse_load = (state_d == WS_FIRE) && ((state_q != WS_FIRE) || soft_req);

    wdt_pulse_len #(.PULSE_W(PULSE_W)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .load   (pulse_load),
        .active (state_q == WS_FIRE),
        .ticks  (ticks_q),
        .last   (pulse_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (soft_req) begin
            state_d = WS_FIRE;                        // SOFT
        end else begin
            unique case (state_q)
                WS_STOP: if (start_evt) state_d = WS_RUN;    // START
                WS_RUN: begin
                    if (stop_evt)            state_d = WS_STOP; // HALT
                    else if (cnt_q == '0)    state_d = WS_FIRE; // EXPIRE
                end
                WS_FIRE: if (pulse_last) state_d = WS_STOP;     // RELEASE
                default: state_d = WS_STOP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Count, default and pulse-length registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            dflt_q  <= '1;
            ticks_q <= PULSE_W'(PULSE_RST);
        end else begin
            if (load_val) begin
                dflt_q <= wdata[CNT_W-1:0];
                cnt_q  <= wdata[CNT_W-1:0];
            end else if (state_q == WS_RUN && state_d == WS_RUN) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (state_d != WS_RUN) begin
                cnt_q <= dflt_q;
            end
            if (wr_en && addr == A_TICKS) begin
                ticks_q <= wdata[PULSE_W-1:0];
            end
        end
    end

    // Outputs
    always_comb begin
        wdt_rst_o = (state_q == WS_FIRE);
        rdata     = '0;
        if (addr == A_COUNT) begin
            rdata[CNT_W-1:0] = cnt_q;
        end else if (addr == A_TICKS) begin
            rdata[PULSE_W-1:0] = ticks_q;
        end
    end

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input wdt_state_e        state_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  dflt_q,
    input logic              wdt_rst_o
);

    logic key_word;
    assign key_word = (wdata == KEY_GO_A) || (wdata == KEY_GO_B) ||
                      (wdata == KEY_HALT_A) || (wdata == KEY_HALT_B);

    a_r1_count_down: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_RUN && cnt_q != '0 && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r6_expire: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_RUN && cnt_q == '0 && !wr_en)
            |=> (wdt_rst_o && state_q == WS_FIRE && cnt_q == $past(dflt_q)));

    a_r4_running_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_RUN && wr_en && addr == ADDR_W'(OFS_COUNT) && !key_word)
            |=> (dflt_q == $past(dflt_q)));

    a_r8_soft_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_SOFT) && wdata[0]) |=> wdt_rst_o);

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (!wdt_rst_o && state_q == WS_STOP && dflt_q == '1));

endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .dflt_q    (dflt_q),
    .wdt_rst_o (wdt_rst_o)
);

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;

    localparam int CNT_W = 16;
    localparam int PULSE_W = 8;
    localparam int ADDR_W = 2;
    localparam int PULSE_RST = 4;
    localparam int CMASK = (1 << CNT_W) - 1;
    localparam int PMASK = (1 << PULSE_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdt_keyed #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .ADDR_W(ADDR_W), .PULSE_RST(PULSE_RST)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wdt_rst_o(wdt_rst_o)
    );

    // Behavioural reference: 0 idle, 1 counting, 2 pulsing
    int  m_st = 0, m_cnt = 0, m_dflt = 0, m_ticks = 0, m_left = 0, m_pend = 0;
    bit  m_valid = 0;

    always @(posedge clk) begin
        int  d;
        bit  w0, key, go, halt;
        d    = int'(wdata);
        w0   = wr_en && addr == 0;
        key  = (d == 'hFF00) || (d == 'h00FF) || (d == 'hEE00) || (d == 'h00EE);
        go   = w0 && d == 'h00FF && m_pend == 1;
        halt = w0 && d == 'h00EE && m_pend == 2;
        if (rst) begin
            m_st = 0; m_cnt = CMASK; m_dflt = CMASK; m_ticks = PULSE_RST; m_pend = 0; m_left = 0;
            m_valid = 1;
        end else begin
            if (wr_en && addr == 2 && wdata[0]) begin
                m_st = 2; m_cnt = m_dflt; m_left = (m_ticks == 0) ? 1 : m_ticks;
            end else if (m_st == 0) begin
                if (w0 && !key) begin m_dflt = d & CMASK; m_cnt = m_dflt; end
                if (go) m_st = 1;
            end else if (m_st == 1) begin
                if (halt) begin m_st = 0; m_cnt = m_dflt; end
                else if (m_cnt == 0) begin
                    m_st = 2; m_cnt = m_dflt; m_left = (m_ticks == 0) ? 1 : m_ticks;
                end else m_cnt = m_cnt - 1;
            end else begin
                if (w0 && !key) begin m_dflt = d & CMASK; m_cnt = m_dflt; end
                m_left = m_left - 1;
                if (m_left <= 0) m_st = 0;
            end
            if (wr_en && addr == 1) m_ticks = d & PMASK;
            if (wr_en) begin
                if (w0 && d == 'hFF00) m_pend = 1;
                else if (w0 && d == 'hEE00) m_pend = 2;
                else m_pend = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (m_valid && !done) begin
            checks++;
            if (wdt_rst_o !== (m_st == 2)) begin
                errors++;
                $display("FAIL R6 model: wdt_rst_o act=%0b exp=%0b", wdt_rst_o, (m_st == 2));
            end
            if (addr == 0) begin
                checks++;
                if (rdata !== 32'(m_cnt)) begin
                    errors++;
                    $display("FAIL R3 model: count act=%0d exp=%0d", rdata, m_cnt);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        addr  = ADDR_W'(a);
        wdata = 32'(d);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = '0;
    endtask

    task automatic rd(input int a, output int v);
        addr = ADDR_W'(a);
        #1;
        v = int'(rdata);
        addr = '0;
    endtask

    task automatic go_start();
        wr(0, 'hFF00);
        wr(0, 'h00FF);
    endtask

    task automatic go_stop();
        wr(0, 'hEE00);
        wr(0, 'h00EE);
    endtask

    // Waits for the pulse; returns negedges waited (0 if never)
    task automatic wait_pulse(output int n);
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (wdt_rst_o) begin n = i; break; end
        end
    endtask

    // Called at a negedge where the pulse is high; returns its total length
    task automatic pulse_len(input int already, output int n);
        n = already;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!wdt_rst_o) break;
            n++;
        end
    endtask

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        rd(0, v); chk("R9 count all ones", v, CMASK);
        rd(1, v); chk("R9 ticks reset", v, PULSE_RST);
        chk("R9 output low", int'(wdt_rst_o), 0);
        rd(2, v); chk("R3 soft reg reads zero", v, 0);

        // R4 load while idle
        wr(0, 20);
        rd(0, v); chk("R4 load idle", v, 20);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R4 idle holds", v, 20);

        // R1 start
        go_start();
        rd(0, v); chk("R1 count at start", v, 20);
        repeat (5) @(negedge clk);
        rd(0, v); chk("R1 count decrements", v, 15);

        // R4 write while running ignored
        wr(0, 99);
        rd(0, v); chk("R4 running write ignored", v, 14);

        // R2 stop reloads default
        go_stop();
        rd(0, v); chk("R2 stop reload", v, 20);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R2 stays stopped", v, 20);

        // R5 broken pair
        wr(0, 'hFF00); wr(1, PULSE_RST); wr(0, 'h00FF);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R5 broken pair no start", v, 20);
        // R5 re-arm
        wr(0, 'hFF00); wr(0, 'hFF00); wr(0, 'h00FF);
        repeat (2) @(negedge clk);
        rd(0, v); chk("R5 re-arm starts", v, 18);
        go_stop();
        // R5 crossed pair
        wr(0, 'hFF00); wr(0, 'h00EE);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R5 crossed pair ignored", v, 20);

        // R6 expiry and R7 pulse length
        wr(0, 10);
        go_start();
        wait_pulse(n); chk("R6 expiry cycle", n, 11);
        rd(0, v); chk("R6 count reloaded", v, 10);
        pulse_len(1, n); chk("R7 pulse length 4", n, 4);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R6 idle after expiry", v, 10);

        // R10 start during pulse ignored, R7 length 6
        wr(1, 6);
        go_start();
        wait_pulse(n); chk("R6 expiry cycle 2", n, 11);
        go_start();
        pulse_len(3, n); chk("R7 pulse length 6", n, 6);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R10 start in pulse ignored", v, 10);

        // R7 zero ticks, R8 soft request
        wr(1, 0);
        wr(2, 1);
        chk("R8 soft pulse high", int'(wdt_rst_o), 1);
        pulse_len(1, n); chk("R7 zero ticks acts as one", n, 1);
        wr(2, 0);
        repeat (3) @(negedge clk);
        chk("R8 write zero no pulse", int'(wdt_rst_o), 0);

        // R8 soft while running
        wr(1, 3);
        go_start();
        repeat (4) @(negedge clk);
        wr(2, 1);
        rd(0, v); chk("R8 soft reloads count", v, 10);
        pulse_len(1, n); chk("R8 soft pulse length", n, 3);

        // R2 stop prevents expiry
        go_start();
        repeat (5) @(negedge clk);
        go_stop();
        wait_pulse(n); chk("R2 no expiry after stop", n, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule